// File: doc/BRIEF.md
# Host Event Input Queue

This block is a small memory-mapped queue between a host that produces input event words and a processor that consumes them. The host side offers one 32-bit event per cycle on a valid strobe and is never stalled. The processor side is a register port with three offsets. Software uses them to take events from the head, read how many are waiting, and read how many were lost. A level output stays high while any event is waiting, so it can serve as an interrupt request.

When all sixteen slots are occupied, a new event is thrown away rather than written over a stored one. Each loss increments a drop counter that stops at its top value. Software clears that counter with a write to its offset. A separate drain-enable input decides whether a data read actually consumes the head entry. When it is low, the same read only looks at the head and leaves it in place.

Top module: `evq_top`

## Requirements
- R1: Accepted event words (32 bits) are stored in up to 16 slots and leave the queue in the order they arrived.
- R2: A read of offset 0x4 returns the number of waiting events in bits [4:0], a nonempty flag in bit 8 and a full flag (16 waiting) in bit 9, with all other bits zero.
- R3: An event offered while 16 are waiting, with no pop in the same cycle, is discarded. Stored entries are unchanged and the drop counter at offset 0x8 increases by one.
- R4: The 16-bit drop counter stops at 0xFFFF and does not wrap on further drops.
- R5: A write of any value to offset 0x8 sets the drop counter to zero. If a drop happens in the same cycle, the clear takes precedence and the counter reads zero afterwards.
- R6: The `irq` output is high exactly while at least one event is waiting.
- R7: A read of offset 0x0 with `drain_en` high returns the head entry and removes it. Once every waiting event has been taken, the status count reads zero.
- R8: A read of offset 0x0 with `drain_en` low returns the head entry without removing it.
- R9: A read of offset 0x0 while nothing is waiting and no event is arriving returns zero and changes no state.
- R10: When the queue is full, a pop and a push in the same cycle both succeed and no drop is counted. When it is empty, a draining data read in the same cycle as a push returns the arriving word and the count stays zero.
- R11: Synchronous active-high reset empties the queue and clears the drop counter.
- R12: Reads of any unmapped offset return zero. Writes to offsets 0x0 and 0x4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers an event this cycle |
| host_data | input | 32 | Event word from the host |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| drain_en | input | 1 | Data reads consume the head entry when high |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Level request: events are waiting |

## Verification
If an internal pointer or the count goes wrong, the effect shows at the ports on the next register read. A status read shows the wrong count, and a data read returns an out-of-order or stale word. `irq` also moves with the count, so an error there shows on the following clock even without a read. The reference model compares read data and `irq` in every cycle, so a bad drop counter, a missed clear or a wrong wrap shows up at the first read of offset 0x8 after the error.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [3:0] {
        OFS_DATA = 4'h0,
        OFS_STAT = 4'h4,
        OFS_DROP = 4'h8
    } evq_ofs_e;

    localparam int STAT_NONEMPTY_BIT = 8;
    localparam int STAT_FULL_BIT     = 9;

endpackage

// File: rtl/evq_store.sv
module evq_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_ptr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_ptr];

endmodule

// File: rtl/evq_occupancy.sv
module evq_occupancy #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } occ_state_t;

    occ_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_SLOT) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_SLOT) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign count  = st_q.count;
    assign empty  = (st_q.count == '0);
    assign full   = (st_q.count == CNT_FULL);

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL); // R1

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - 1'b1)); // R7

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (count == $past(count) + 1'b1)); // R1

endmodule

// File: rtl/evq_dropctr.sv
module evq_dropctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] value
);

    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (clr) begin
            value_d = '0;
        end else if (inc && (value_q != TOP)) begin
            value_d = value_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

    assign value = value_q;

    AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (value == TOP && !clr) |=> (value == TOP)); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0)); // R5

endmodule

// File: rtl/evq_top.sv
module evq_top #(
    parameter int WIDTH  = 32,
    parameter int DEPTH  = 16,
    parameter int DROP_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_valid,
    input  logic [31:0]      host_data,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic             drain_en,
    output logic [31:0]      bus_rdata,
    output logic             irq
);

    import evq_pkg::*;

    localparam logic [DROP_W-1:0] DROP_TOP = {DROP_W{1'b1}};

    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              empty, full;
    logic [WIDTH-1:0]  head_word;
    logic [DROP_W-1:0] drop_val;

    logic rd_data_reg, wr_drop_reg;
    logic pop_ok, bypass, push_store, pop_mem, drop_now;
    logic [31:0] stat_word;

    always_comb begin
        rd_data_reg = bus_sel && !bus_we && (bus_addr == OFS_DATA);
        wr_drop_reg = bus_sel &&  bus_we && (bus_addr == OFS_DROP);
        pop_ok      = rd_data_reg && drain_en && (!empty || host_valid);
        bypass      = pop_ok && empty;
        pop_mem     = pop_ok && !empty;
        push_store  = host_valid && !bypass && (!full || pop_mem);
        drop_now    = host_valid && full && !pop_mem;
    end

    always_comb begin
        stat_word = '0;
        stat_word[CNT_W-1:0]       = count;
        stat_word[STAT_NONEMPTY_BIT] = !empty;
        stat_word[STAT_FULL_BIT]     = full;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_DATA: begin
                    if (!empty) begin
                        bus_rdata = 32'(head_word);
                    end else if (bypass) begin
                        bus_rdata = host_data;
                    end
                end
                OFS_STAT: bus_rdata = stat_word;
                OFS_DROP: bus_rdata = 32'(drop_val);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = !empty;

    evq_occupancy #(.DEPTH(DEPTH)) occ_i (
        .clk    (clk),
        .rst    (rst),
        .push   (push_store),
        .pop    (pop_mem),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .empty  (empty),
        .full   (full)
    );

    evq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (push_store),
        .wr_ptr  (wr_ptr),
        .wr_data (host_data[WIDTH-1:0]),
        .rd_ptr  (rd_ptr),
        .rd_data (head_word)
    );

    evq_dropctr #(.CW(DROP_W)) drop_i (
        .clk   (clk),
        .rst   (rst),
        .inc   (drop_now),
        .clr   (wr_drop_reg),
        .value (drop_val)
    );

    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (host_valid && full && !pop_ok && !wr_drop_reg && drop_val != DROP_TOP)
        |=> (drop_val == $past(drop_val) + 1'b1)); // R3

    AST_FULL_STAYS_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (host_valid && full && !pop_ok) |=> full); // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data_reg && empty && !(host_valid && drain_en)) |-> (bus_rdata == '0)); // R9

    AST_BYPASS_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_ok) |=> empty); // R10

    AST_FULL_SWAP_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && host_valid && pop_ok && !wr_drop_reg) |=> ($stable(drop_val) && full)); // R10

    AST_IRQ_NEEDS_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(host_valid)); // R6

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_data_reg && !drain_en && !host_valid) |=> $stable(count)); // R8

endmodule

// File: tb/evq_top_tb.sv
module evq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic [31:0] host_data = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        drain_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int unsigned mq[$];
    int unsigned mdrop = 0;

    always #10 clk = ~clk;

    evq_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_data  (host_data),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .drain_en   (drain_en),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic v, input logic [31:0] d,
                                              input logic s, input logic w,
                                              input logic [3:0] a, input logic dr);
        logic [31:0] r = '0;
        if (s && !w) begin
            if (a == 4'h0) begin
                if (mq.size() > 0) r = mq[0];
                else if (v && dr) r = d;
            end else if (a == 4'h4) begin
                r = 32'(mq.size());
                if (mq.size() > 0) r[8] = 1'b1;
                if (mq.size() == 16) r[9] = 1'b1;
            end else if (a == 4'h8) begin
                r = mdrop;
            end
        end
        return r;
    endfunction

    task automatic step(input logic v, input logic [31:0] d, input logic s, input logic w,
                        input logic [3:0] a, input logic dr, input string tag);
        bit popok, dropped;
        int sz;
        @(negedge clk);
        host_valid = v; host_data = d; bus_sel = s; bus_we = w; bus_addr = a; drain_en = dr;
        #5;
        check(tag, bus_rdata, exp_rdata(v, d, s, w, a, dr));
        check("R6", {31'b0, irq}, {31'b0, mq.size() > 0});
        @(posedge clk);
        sz = mq.size();
        popok = s && !w && (a == 4'h0) && dr && (sz > 0 || v);
        dropped = 0;
        if (!(popok && sz == 0)) begin
            if (popok) void'(mq.pop_front());
            if (v) begin
                if (sz < 16 || popok) mq.push_back(d);
                else dropped = 1;
            end
        end
        if (s && w && a == 4'h8) mdrop = 0;
        else if (dropped && mdrop < 32'hFFFF) mdrop++;
    endtask

    task automatic push(input logic [31:0] d, input string tag);
        step(1'b1, d, 1'b0, 1'b0, 4'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input logic dr, input string tag);
        step(1'b0, 32'h0, 1'b1, 1'b0, a, dr, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        host_valid = 0; bus_sel = 0; bus_we = 0; drain_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
        mdrop = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 200000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R11: reset state
        rd(4'h4, 1'b0, "R11");
        rd(4'h8, 1'b0, "R11");

        // R1, R2, R6: several pushes, then status
        for (int i = 0; i < 5; i++) push(32'hA000_0000 + i, "R1");
        rd(4'h4, 1'b0, "R2");
        // R8: peek without drain
        rd(4'h0, 1'b0, "R8");
        rd(4'h0, 1'b0, "R8");
        rd(4'h4, 1'b0, "R8");
        // R7: drain in order
        for (int i = 0; i < 5; i++) rd(4'h0, 1'b1, "R7");
        rd(4'h4, 1'b0, "R7");
        // R9: empty read
        rd(4'h0, 1'b1, "R9");
        rd(4'h4, 1'b0, "R9");

        // R2, R3: fill and overflow
        for (int i = 0; i < 16; i++) push(32'hB000_0000 + i * 3, "R1");
        rd(4'h4, 1'b0, "R2");
        for (int i = 0; i < 3; i++) push(32'hDEAD_0000 + i, "R3");
        rd(4'h8, 1'b0, "R3");
        rd(4'h4, 1'b0, "R3");
        // R10: full push and pop together
        step(1'b1, 32'hC0DE_0001, 1'b1, 1'b0, 4'h0, 1'b1, "R10");
        rd(4'h8, 1'b0, "R10");
        rd(4'h4, 1'b0, "R10");
        for (int i = 0; i < 16; i++) rd(4'h0, 1'b1, "R1");
        rd(4'h4, 1'b0, "R7");
        // R10: empty bypass
        step(1'b1, 32'h1234_5678, 1'b1, 1'b0, 4'h0, 1'b1, "R10");
        rd(4'h4, 1'b0, "R10");

        // R5: clear, and clear against a same-cycle drop
        step(1'b0, 32'h0, 1'b1, 1'b1, 4'h8, 1'b0, "R5");
        rd(4'h8, 1'b0, "R5");
        for (int i = 0; i < 17; i++) push(32'h5500_0000 + i, "R3");
        rd(4'h8, 1'b0, "R3");
        step(1'b1, 32'h5555_5555, 1'b1, 1'b1, 4'h8, 1'b0, "R5");
        rd(4'h8, 1'b0, "R5");

        // R12: unmapped and read-only offsets
        rd(4'hC, 1'b0, "R12");
        rd(4'h2, 1'b1, "R12");
        step(1'b0, 32'h0, 1'b1, 1'b1, 4'h0, 1'b1, "R12");
        step(1'b0, 32'h0, 1'b1, 1'b1, 4'h4, 1'b1, "R12");
        rd(4'h4, 1'b0, "R12");
        rd(4'h0, 1'b0, "R12");

        // R4: saturation of the drop counter
        for (int i = 0; i < 65540; i++) push(i, "R4");
        rd(4'h8, 1'b0, "R4");
        push(32'hFFFF_0000, "R4");
        rd(4'h8, 1'b0, "R4");

        // R11: reset while in use
        do_reset();
        rd(4'h4, 1'b0, "R11");
        rd(4'h8, 1'b0, "R11");
        rd(4'h0, 1'b1, "R11");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule